// File: doc/BRIEF.md
# Debug Abstract Register Command Engine

This block sits between a debugger's register interface and a halted processor core. The debugger writes a 32-bit command word. When the word selects the register-access command type, the engine checks it and then moves one word between its own data latch and a core register. The core register is reached over a request/response bus on which the engine is the requester and the address is the register number. After a successful access the engine can step the register number by one. It can also ask for the program buffer to be run, and it waits for that run to finish before it goes idle.

The engine keeps a busy flag and a 3-bit sticky error code, which the debugger clears by writing ones to its bits. While the error code is non-zero, new commands are dropped without effect. The debugger loads the data latch directly between commands and reads it back after a read transfer.

Top module: `abscmd_engine`

## Requirements
- R1: A command whose type field (bits 31:24) is not 0, or whose bit 23 is set, sets the error code to 2 and issues no bus request.
- R2: With transfer (bit 17) set, a size field (bits 22:20) other than 2 sets the error code to 2. With transfer clear, the size field is not checked and the command is accepted.
- R3: A valid command written while halted_i is low sets the error code to 4 and starts nothing.
- R4: An accepted command with transfer set and write (bit 16) set issues a request in the cycle after acceptance, for exactly one cycle, with we=1, the address equal to the register number (bits 15:0) and the write data equal to the data latch.
- R5: With transfer set and write clear, a good response loads the response data into the data latch.
- R6: With transfer clear, no bus request is made, the write bit has no effect and the register number is not incremented.
- R7: With post-increment (bit 19) set, a good response advances regno_o by one, wrapping from 0xFFFF to 0.
- R8: A response flagged as an error sets the error code to 5. The data latch and regno_o keep their values and no program-buffer run is requested.
- R9: With post-execute (bit 18) set, progbuf_go_o pulses for one cycle after the transfer, or at once when there is no transfer. busy_o stays high until progbuf_done_i, and progbuf_exc_i at that point sets the error code to 3.
- R10: A command written while busy with error code 0 sets the error code to 1, and the running command still completes.
- R11: While the error code is non-zero, a command write has no effect.
- R12: The error code is sticky: once it is non-zero, later errors do not replace it. A clear write clears exactly the bits set in its mask, and a partial clear leaves the remaining bits.
- R13: A data latch write while busy is ignored.
- R14: After reset busy_o, cmderr_o, data_o, regno_o, reg_req_o and progbuf_go_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_wr_i | input | 1 | Command word write strobe |
| cmd_wdata_i | input | 32 | Command word |
| errclr_wr_i | input | 1 | Error clear strobe |
| errclr_mask_i | input | 3 | Error bits to clear |
| data_wr_i | input | 1 | Data latch write strobe |
| data_wdata_i | input | DATA_W | Data latch write value |
| data_o | output | DATA_W | Data latch |
| busy_o | output | 1 | Command in progress |
| cmderr_o | output | 3 | Sticky error code |
| regno_o | output | 16 | Current register number |
| halted_i | input | 1 | Core is halted |
| reg_req_o | output | 1 | Register bus request, one cycle |
| reg_we_o | output | 1 | Request is a write |
| reg_addr_o | output | 16 | Register number |
| reg_wdata_o | output | DATA_W | Write data |
| reg_rsp_valid_i | input | 1 | Response valid |
| reg_rsp_err_i | input | 1 | Response carries an error |
| reg_rsp_rdata_i | input | DATA_W | Response read data |
| progbuf_go_o | output | 1 | Start program buffer run, one cycle |
| progbuf_done_i | input | 1 | Program buffer run finished |
| progbuf_exc_i | input | 1 | Run ended in an exception, valid with done |

## Verification
The bench drives reads and writes, with and without post-increment and post-execute, through a responder whose latency and failing address are set per test. A behavioural model is compared with the outputs every cycle. Malformed words are sent in separate tests: a bad type, bit 23 set and a bad size with and without transfer. This separates a decode that checks size in every case from one that checks it only when transfer is set. Commands written during a transfer, commands written with an error pending, and data writes made while busy show whether a dropped input leaves the latch, the register number and the request count unchanged. Partial clears and a bus error that follows a busy error show whether the code is sticky and cleared bit by bit.

// File: rtl/abscmd_pkg.sv
package abscmd_pkg;
  localparam int unsigned CMD_W   = 32;
  localparam int unsigned REGNO_W = 16;
  localparam int unsigned ERR_W   = 3;

  typedef enum logic [ERR_W-1:0] {
    ERR_NONE  = 3'd0,
    ERR_BUSY  = 3'd1,
    ERR_UNSUP = 3'd2,
    ERR_EXC   = 3'd3,
    ERR_HART  = 3'd4,
    ERR_BUS   = 3'd5,
    ERR_RSVD  = 3'd6,
    ERR_OTHER = 3'd7
  } err_e;

  // field layout is fixed by the debugger side
  typedef struct packed {
    logic [7:0]         kind;
    logic               pad;
    logic [2:0]         size;
    logic               post_inc;
    logic               post_exec;
    logic               xfer;
    logic               wr;
    logic [REGNO_W-1:0] regno;
  } cmd_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_WAIT, S_PB_GO, S_PB_WAIT
  } seq_e;
endpackage

// File: rtl/abscmd_decode.sv
module abscmd_decode
  import abscmd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             halted_i,
  output cmd_t             fields_o,
  output err_e             err_o
);
  localparam logic [2:0] SIZE_CODE = 3'($clog2(DATA_W / 8));

  assign fields_o = cmd_t'(cmd_i);

  always_comb begin
    err_o = ERR_NONE;
    if (fields_o.kind != 8'd0 || fields_o.pad)
      err_o = ERR_UNSUP;
    else if (fields_o.xfer && fields_o.size != SIZE_CODE)
      err_o = ERR_UNSUP;
    else if (!halted_i)
      err_o = ERR_HART;
  end
endmodule

// File: rtl/abscmd_err.sv
module abscmd_err
  import abscmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_set_i,
  input  err_e             cmd_code_i,
  input  logic             seq_set_i,
  input  err_e             seq_code_i,
  input  logic             clr_wr_i,
  input  logic [ERR_W-1:0] clr_mask_i,
  output err_e             err_o
);
  err_e err_q, err_d;

  // first error wins; command-side error has priority in a tie
  always_comb begin
    err_d = err_q;
    if (err_q == ERR_NONE) begin
      if (cmd_set_i)      err_d = cmd_code_i;
      else if (seq_set_i) err_d = seq_code_i;
    end else if (clr_wr_i) begin
      err_d = err_e'(err_q & ~clr_mask_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= ERR_NONE;
    else         err_q <= err_d;
  end

  assign err_o = err_q;
endmodule

// File: rtl/abscmd_seq.sv
module abscmd_seq
  import abscmd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               start_xfer_i,
  input  logic               start_wr_i,
  input  logic               start_inc_i,
  input  logic               start_exec_i,
  input  logic [REGNO_W-1:0] start_regno_i,
  input  logic               data_wr_i,
  input  logic [DATA_W-1:0]  data_wdata_i,
  output logic               busy_o,
  output logic [DATA_W-1:0]  data_o,
  output logic [REGNO_W-1:0] regno_o,
  output logic               req_o,
  output logic               we_o,
  output logic [REGNO_W-1:0] addr_o,
  output logic [DATA_W-1:0]  wdata_o,
  input  logic               rsp_valid_i,
  input  logic               rsp_err_i,
  input  logic [DATA_W-1:0]  rsp_rdata_i,
  output logic               go_o,
  input  logic               pb_done_i,
  input  logic               pb_exc_i,
  output logic               fail_o,
  output err_e               fail_code_o
);
  seq_e               st_q, st_d;
  logic               wr_q, inc_q, exec_q;
  logic [REGNO_W-1:0] regno_q, regno_d;
  logic [DATA_W-1:0]  data_q, data_d;
  logic               rsp_ok;

  assign rsp_ok = (st_q == S_WAIT) && rsp_valid_i && !rsp_err_i;

  always_comb begin
    st_d        = st_q;
    regno_d     = regno_q;
    data_d      = data_q;
    fail_o      = 1'b0;
    fail_code_o = ERR_NONE;
    unique case (st_q)
      S_IDLE: begin
        if (data_wr_i) data_d = data_wdata_i;
        if (start_i) begin
          regno_d = start_regno_i;
          if (start_xfer_i)      st_d = S_ISSUE;
          else if (start_exec_i) st_d = S_PB_GO;
        end
      end
      S_ISSUE: st_d = S_WAIT;
      S_WAIT: begin
        if (rsp_valid_i) begin
          if (rsp_err_i) begin
            fail_o      = 1'b1;
            fail_code_o = ERR_BUS;
            st_d        = S_IDLE;
          end else begin
            st_d = exec_q ? S_PB_GO : S_IDLE;
          end
        end
        if (rsp_ok && !wr_q)  data_d  = rsp_rdata_i;
        if (rsp_ok && inc_q)  regno_d = regno_q + 1'b1;
      end
      S_PB_GO: st_d = S_PB_WAIT;
      S_PB_WAIT: begin
        if (pb_done_i) begin
          st_d = S_IDLE;
          if (pb_exc_i) begin
            fail_o      = 1'b1;
            fail_code_o = ERR_EXC;
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      wr_q    <= 1'b0;
      inc_q   <= 1'b0;
      exec_q  <= 1'b0;
      regno_q <= '0;
      data_q  <= '0;
    end else begin
      st_q    <= st_d;
      regno_q <= regno_d;
      data_q  <= data_d;
      if (start_i && st_q == S_IDLE) begin
        wr_q   <= start_wr_i;
        inc_q  <= start_inc_i;
        exec_q <= start_exec_i;
      end
    end
  end

  assign busy_o  = (st_q != S_IDLE);
  assign req_o   = (st_q == S_ISSUE);
  assign we_o    = wr_q;
  assign addr_o  = regno_q;
  assign wdata_o = data_q;
  assign go_o    = (st_q == S_PB_GO);
  assign data_o  = data_q;
  assign regno_o = regno_q;
endmodule

// File: rtl/abscmd_engine.sv
module abscmd_engine
  import abscmd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_wr_i,
  input  logic [31:0]        cmd_wdata_i,
  input  logic               errclr_wr_i,
  input  logic [2:0]         errclr_mask_i,
  input  logic               data_wr_i,
  input  logic [DATA_W-1:0]  data_wdata_i,
  output logic [DATA_W-1:0]  data_o,
  output logic               busy_o,
  output logic [2:0]         cmderr_o,
  output logic [15:0]        regno_o,
  input  logic               halted_i,
  output logic               reg_req_o,
  output logic               reg_we_o,
  output logic [15:0]        reg_addr_o,
  output logic [DATA_W-1:0]  reg_wdata_o,
  input  logic               reg_rsp_valid_i,
  input  logic               reg_rsp_err_i,
  input  logic [DATA_W-1:0]  reg_rsp_rdata_i,
  output logic               progbuf_go_o,
  input  logic               progbuf_done_i,
  input  logic               progbuf_exc_i
);
  cmd_t fields;
  err_e dec_err, err_q, seq_code;
  logic busy, seq_fail, err_clean, cmd_live, accept, cmd_set;

  abscmd_decode #(.DATA_W(DATA_W)) u_dec (
    .cmd_i    (cmd_wdata_i),
    .halted_i (halted_i),
    .fields_o (fields),
    .err_o    (dec_err)
  );

  assign err_clean = (err_q == ERR_NONE);
  assign cmd_live  = cmd_wr_i && err_clean;
  assign accept    = cmd_live && !busy && (dec_err == ERR_NONE);
  assign cmd_set   = cmd_live && (busy || dec_err != ERR_NONE);

  abscmd_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (accept),
    .start_xfer_i  (fields.xfer),
    .start_wr_i    (fields.wr),
    .start_inc_i   (fields.post_inc),
    .start_exec_i  (fields.post_exec),
    .start_regno_i (fields.regno),
    .data_wr_i     (data_wr_i),
    .data_wdata_i  (data_wdata_i),
    .busy_o        (busy),
    .data_o        (data_o),
    .regno_o       (regno_o),
    .req_o         (reg_req_o),
    .we_o          (reg_we_o),
    .addr_o        (reg_addr_o),
    .wdata_o       (reg_wdata_o),
    .rsp_valid_i   (reg_rsp_valid_i),
    .rsp_err_i     (reg_rsp_err_i),
    .rsp_rdata_i   (reg_rsp_rdata_i),
    .go_o          (progbuf_go_o),
    .pb_done_i     (progbuf_done_i),
    .pb_exc_i      (progbuf_exc_i),
    .fail_o        (seq_fail),
    .fail_code_o   (seq_code)
  );

  abscmd_err u_err (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_set_i  (cmd_set),
    .cmd_code_i (busy ? ERR_BUSY : dec_err),
    .seq_set_i  (seq_fail),
    .seq_code_i (seq_code),
    .clr_wr_i   (errclr_wr_i),
    .clr_mask_i (errclr_mask_i),
    .err_o      (err_q)
  );

  assign busy_o   = busy;
  assign cmderr_o = err_q;
endmodule

// File: rtl/abscmd_checker.sv
module abscmd_checker #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_wr_i,
  input logic [7:0]        cmd_kind_i,
  input logic              cmd_pad_i,
  input logic [2:0]        cmd_size_i,
  input logic              cmd_xfer_i,
  input logic              errclr_wr_i,
  input logic              data_wr_i,
  input logic              halted_i,
  input logic              reg_rsp_valid_i,
  input logic              reg_rsp_err_i,
  input logic [DATA_W-1:0] data_o,
  input logic              busy_o,
  input logic [2:0]        cmderr_o,
  input logic              reg_req_o,
  input logic              progbuf_go_o
);
  logic fresh;
  assign fresh = cmd_wr_i && !busy_o && cmderr_o == 3'd0;

  assert_unsup_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fresh && (cmd_kind_i != 8'd0 || cmd_pad_i)) |=> cmderr_o == 3'd2);

  assert_size_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fresh && cmd_kind_i == 8'd0 && !cmd_pad_i && cmd_xfer_i && cmd_size_i != 3'd2)
      |=> cmderr_o == 3'd2);

  assert_hart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fresh && cmd_kind_i == 8'd0 && !cmd_pad_i && !(cmd_xfer_i && cmd_size_i != 3'd2)
      && !halted_i) |=> (cmderr_o == 3'd4 && !busy_o));

  assert_req_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o |-> busy_o);

  assert_req_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o |=> !reg_req_o);

  assert_bus_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && reg_rsp_valid_i && reg_rsp_err_i && cmderr_o == 3'd0 && !cmd_wr_i)
      |=> (cmderr_o == 3'd5 && !progbuf_go_o));

  assert_go_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    progbuf_go_o |=> !progbuf_go_o);

  assert_busy_cmd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && busy_o && cmderr_o == 3'd0) |=> cmderr_o == 3'd1);

  assert_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && !busy_o && cmderr_o != 3'd0) |=> !busy_o);

  assert_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmderr_o != 3'd0 && !errclr_wr_i) |=> $stable(cmderr_o));

  assert_data_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr_i && busy_o && !reg_rsp_valid_i) |=> $stable(data_o));
endmodule

bind abscmd_engine abscmd_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .cmd_wr_i        (cmd_wr_i),
  .cmd_kind_i      (cmd_wdata_i[31:24]),
  .cmd_pad_i       (cmd_wdata_i[23]),
  .cmd_size_i      (cmd_wdata_i[22:20]),
  .cmd_xfer_i      (cmd_wdata_i[17]),
  .errclr_wr_i     (errclr_wr_i),
  .data_wr_i       (data_wr_i),
  .halted_i        (halted_i),
  .reg_rsp_valid_i (reg_rsp_valid_i),
  .reg_rsp_err_i   (reg_rsp_err_i),
  .data_o          (data_o),
  .busy_o          (busy_o),
  .cmderr_o        (cmderr_o),
  .reg_req_o       (reg_req_o),
  .progbuf_go_o    (progbuf_go_o)
);

// File: tb/sim_abscmd_engine.sv
`timescale 1ns/1ps
module sim_abscmd_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_wr_i = 1'b0;
  logic [31:0] cmd_wdata_i = '0;
  logic        errclr_wr_i = 1'b0;
  logic [2:0]  errclr_mask_i = '0;
  logic        data_wr_i = 1'b0;
  logic [31:0] data_wdata_i = '0;
  logic [31:0] data_o;
  logic        busy_o;
  logic [2:0]  cmderr_o;
  logic [15:0] regno_o;
  logic        halted_i = 1'b1;
  logic        reg_req_o, reg_we_o;
  logic [15:0] reg_addr_o;
  logic [31:0] reg_wdata_o;
  logic        reg_rsp_valid_i = 1'b0;
  logic        reg_rsp_err_i = 1'b0;
  logic [31:0] reg_rsp_rdata_i = '0;
  logic        progbuf_go_o;
  logic        progbuf_done_i = 1'b0;
  logic        progbuf_exc_i = 1'b0;

  abscmd_engine u0 (.*);

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // responder and program-buffer stubs
  int          lat = 1, cnt = 0, pbc = 0;
  logic [15:0] bad_addr = 16'hFFF0, rq_addr = '0;
  logic        pb_exc_sel = 1'b0;
  int          req_cnt = 0, go_cnt = 0;
  logic [15:0] last_addr = '0;
  logic [31:0] last_data = '0;
  logic        last_we = 1'b0;

  always @(posedge clk_i) begin
    reg_rsp_valid_i <= 1'b0;
    reg_rsp_err_i   <= 1'b0;
    progbuf_done_i  <= 1'b0;
    progbuf_exc_i   <= 1'b0;
    if (reg_req_o) begin
      cnt <= lat; rq_addr <= reg_addr_o; req_cnt <= req_cnt + 1;
      last_addr <= reg_addr_o; last_data <= reg_wdata_o; last_we <= reg_we_o;
    end else if (cnt > 0) begin
      if (cnt == 1) begin
        reg_rsp_valid_i <= 1'b1;
        reg_rsp_err_i   <= (rq_addr == bad_addr);
        reg_rsp_rdata_i <= 32'hC0DE0000 ^ {16'h0, rq_addr};
      end
      cnt <= cnt - 1;
    end
    if (progbuf_go_o) begin
      pbc <= 2; go_cnt <= go_cnt + 1;
    end else if (pbc > 0) begin
      if (pbc == 1) begin
        progbuf_done_i <= 1'b1; progbuf_exc_i <= pb_exc_sel;
      end
      pbc <= pbc - 1;
    end
  end

  // behavioural reference model
  int          m_ph;        // 0 idle, 1 request, 2 awaiting response, 3 run start, 4 run wait
  logic [2:0]  m_err;
  logic [31:0] m_data;
  logic [15:0] m_regno;
  logic        m_we, m_pi, m_pe;
  int          o_ph, cs, ss;
  logic [2:0]  o_err;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_err = 0; m_data = 0; m_regno = 0; m_we = 0; m_pi = 0; m_pe = 0;
    end else begin
      o_ph = m_ph; o_err = m_err; cs = 0; ss = 0;
      case (o_ph)
        1: m_ph = 2;
        2: if (reg_rsp_valid_i) begin
             if (reg_rsp_err_i) begin ss = 5; m_ph = 0; end
             else begin
               if (!m_we) m_data = reg_rsp_rdata_i;
               if (m_pi) m_regno = m_regno + 16'd1;
               m_ph = m_pe ? 3 : 0;
             end
           end
        3: m_ph = 4;
        4: if (progbuf_done_i) begin
             if (progbuf_exc_i) ss = 3;
             m_ph = 0;
           end
        default: ;
      endcase
      if (o_ph == 0 && data_wr_i) m_data = data_wdata_i;
      if (cmd_wr_i && o_err == 0) begin
        if (o_ph != 0) cs = 1;
        else if (cmd_wdata_i[31:23] != 0) cs = 2;
        else if (cmd_wdata_i[17] && cmd_wdata_i[22:20] != 3'd2) cs = 2;
        else if (!halted_i) cs = 4;
        else begin
          m_regno = cmd_wdata_i[15:0];
          m_we = cmd_wdata_i[16]; m_pi = cmd_wdata_i[19]; m_pe = cmd_wdata_i[18];
          m_ph = cmd_wdata_i[17] ? 1 : (cmd_wdata_i[18] ? 3 : 0);
        end
      end
      if (o_err == 0) begin
        if (cs != 0) m_err = 3'(cs);
        else if (ss != 0) m_err = 3'(ss);
      end else if (errclr_wr_i) m_err = o_err & ~errclr_mask_i;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      check("R10 busy", {31'd0, busy_o}, {31'd0, m_ph != 0});
      check("R12 cmderr", {29'd0, cmderr_o}, {29'd0, m_err});
      check("R5 data", data_o, m_data);
      check("R7 regno", {16'd0, regno_o}, {16'd0, m_regno});
      check("R4 req", {31'd0, reg_req_o}, {31'd0, m_ph == 1});
      check("R9 go", {31'd0, progbuf_go_o}, {31'd0, m_ph == 3});
      if (m_ph == 1) begin
        check("R4 we", {31'd0, reg_we_o}, {31'd0, m_we});
        check("R4 addr", {16'd0, reg_addr_o}, {16'd0, m_regno});
        check("R4 wdata", reg_wdata_o, m_data);
      end
    end
  end

  function automatic logic [31:0] mk(input logic [7:0] ty, input logic [2:0] sz,
      input logic pi, input logic pe, input logic tr, input logic we, input logic [15:0] rn);
    return {ty, 1'b0, sz, pi, pe, tr, we, rn};
  endfunction

  task automatic cmd(input logic [31:0] w);
    @(posedge clk_i); #2 cmd_wr_i = 1'b1; cmd_wdata_i = w;
    @(posedge clk_i); #2 cmd_wr_i = 1'b0;
  endtask

  task automatic dwr(input logic [31:0] d);
    @(posedge clk_i); #2 data_wr_i = 1'b1; data_wdata_i = d;
    @(posedge clk_i); #2 data_wr_i = 1'b0;
  endtask

  task automatic eclr(input logic [2:0] m);
    @(posedge clk_i); #2 errclr_wr_i = 1'b1; errclr_mask_i = m;
    @(posedge clk_i); #2 errclr_wr_i = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1; n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    @(negedge clk_i);
    check("R14 busy", {31'd0, busy_o}, 0);
    check("R14 err", {29'd0, cmderr_o}, 0);
    check("R14 data", data_o, 0);
    check("R14 regno", {16'd0, regno_o}, 0);
    check("R14 req/go", {30'd0, reg_req_o, progbuf_go_o}, 0);

    dwr(32'h11223344);
    cmd(mk(0, 2, 0, 0, 1, 1, 16'h1000)); idle();
    check("R4 wr addr", {16'd0, last_addr}, 32'h1000);
    check("R4 wr data", last_data, 32'h11223344);
    check("R4 wr we", {31'd0, last_we}, 1);

    cmd(mk(0, 2, 0, 0, 1, 0, 16'h0020)); idle();
    check("R5 read data", data_o, 32'hC0DE0020);

    cmd(mk(0, 2, 1, 0, 1, 0, 16'hFFFF)); idle();
    check("R7 wrap", {16'd0, regno_o}, 0);
    check("R5 read ffff", data_o, 32'hC0DE0000 ^ 32'hFFFF);
    cmd(mk(0, 2, 1, 0, 1, 0, 16'h0007)); idle();
    check("R7 inc", {16'd0, regno_o}, 8);

    n = req_cnt;
    cmd(mk(0, 2, 1, 0, 0, 1, 16'h0055)); idle();
    check("R6 no req", req_cnt, n);
    check("R6 no inc", {16'd0, regno_o}, 32'h55);
    check("R6 data kept", data_o, 32'hC0DE0007);

    cmd(mk(8'h01, 2, 0, 0, 1, 0, 16'h0030)); idle();
    check("R1 type", {29'd0, cmderr_o}, 2);
    cmd(mk(0, 2, 0, 0, 1, 0, 16'h0030)); idle();
    check("R11 no req", req_cnt, n);
    check("R11 data", data_o, 32'hC0DE0007);
    check("R11 regno", {16'd0, regno_o}, 32'h55);
    eclr(3'b010); idle();
    check("R12 clear", {29'd0, cmderr_o}, 0);
    cmd(mk(0, 2, 0, 0, 1, 0, 16'h0031) | 32'h0080_0000); idle();
    check("R1 bit23", {29'd0, cmderr_o}, 2);
    check("R1 no req", req_cnt, n);
    eclr(3'b111);

    cmd(mk(0, 3, 0, 0, 1, 0, 16'h0032)); idle();
    check("R2 size", {29'd0, cmderr_o}, 2);
    eclr(3'b111);
    cmd(mk(0, 3, 0, 0, 0, 0, 16'h0009)); idle();
    check("R2 no xfer ok", {29'd0, cmderr_o}, 0);
    check("R2 regno", {16'd0, regno_o}, 9);

    halted_i = 1'b0;
    cmd(mk(0, 2, 0, 0, 1, 0, 16'h0033)); idle();
    check("R3 hart", {29'd0, cmderr_o}, 4);
    eclr(3'b011); idle();
    check("R12 partial keep", {29'd0, cmderr_o}, 4);
    eclr(3'b100);
    halted_i = 1'b1;

    n = go_cnt;
    bad_addr = 16'h0044;
    cmd(mk(0, 2, 1, 1, 1, 0, 16'h0044)); idle();
    check("R8 err", {29'd0, cmderr_o}, 5);
    check("R8 regno", {16'd0, regno_o}, 32'h44);
    check("R8 data", data_o, 32'hC0DE0007);
    check("R8 no go", go_cnt, n);
    eclr(3'b001); idle();
    check("R12 partial", {29'd0, cmderr_o}, 4);
    eclr(3'b100);

    pb_exc_sel = 1'b0;
    cmd(mk(0, 2, 0, 1, 1, 0, 16'h0060)); idle();
    check("R9 go", go_cnt, n + 1);
    check("R9 ok", {29'd0, cmderr_o}, 0);
    check("R9 data", data_o, 32'hC0DE0060);
    pb_exc_sel = 1'b1;
    cmd(mk(0, 2, 0, 1, 0, 1, 16'h0061)); idle();
    check("R9 go2", go_cnt, n + 2);
    check("R9 exc", {29'd0, cmderr_o}, 3);
    eclr(3'b111);
    pb_exc_sel = 1'b0;

    lat = 5;
    cmd(mk(0, 2, 0, 0, 1, 0, 16'h0070));
    cmd(mk(0, 2, 0, 0, 1, 0, 16'h0071)); idle();
    check("R10 err", {29'd0, cmderr_o}, 1);
    check("R10 completes", data_o, 32'hC0DE0070);
    bad_addr = 16'h0072;
    cmd(mk(0, 2, 0, 0, 1, 0, 16'h0072)); idle();
    check("R11 stays busy err", {29'd0, cmderr_o}, 1);
    eclr(3'b001);

    dwr(32'hAAAA5555);
    cmd(mk(0, 2, 0, 0, 1, 1, 16'h0080));
    dwr(32'hDEADBEEF); idle();
    check("R13 data", data_o, 32'hAAAA5555);
    check("R13 wdata", last_data, 32'hAAAA5555);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule